// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block turns a byte-wide supply of 53-byte ATM cells into a continuous byte stream ready for a physical link. At every cell boundary it checks whether the upstream store holds a complete user cell. If one is there, it pulls the cell through one byte per clock. If not, it builds an idle cell itself from programmable header fields and a programmable payload byte, so the cell rate seen by the link never drops.

For every cell it computes the header error check (HEC) octet over the four header bytes. It can place that octet in the fifth byte, optionally combined with the coset pattern, and it can corrupt the octet on purpose for link testing. For user cells it also reports whether the HEC that arrived with the header was right. The 48 payload bytes pass through a self-synchronous scrambler that can be bypassed. Two counters track user cells and idle cells. An interval pulse freezes both counts into holding registers and restarts them.

The upstream store is read in show-ahead fashion: `rd_o` requests a byte, and `din_i` must already carry that byte in the same cycle.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: While `rst` is high, `dout_valid`, `dout_soc`, both flags and both held counters are 0. From the first clock after reset the block emits one byte per clock with `dout_valid` high. `dout_soc` is high on byte 0 of every cell, which is every 53rd byte.
- R2: If `cell_rdy_i` is high in the cycle a cell starts, the cell is a user cell. `rd_o` is then high for all 53 of its bytes, and header bytes 0 to 3 are output unchanged one clock later.
- R3: If `cell_rdy_i` is low when a cell starts, the cell is an idle cell. `rd_o` stays low for all 53 bytes. The header bytes are `{idle_gfc,4'h0}`, `8'h00`, `8'h00` and `{4'h0,idle_pti,idle_clp}`. A change of `cell_rdy_i` in mid-cell has no effect on the cell being sent.
- R4: The HEC is a CRC-8 with generator x^8+x^2+x+1 and zero start value, taken over header bytes 0 to 3, most significant bit first. It is placed in byte 4 of every idle cell, and of a user cell when `hec_ins_en` is high. Otherwise a user cell's byte 4 passes unchanged.
- R5: When `coset_en` is high, the generated HEC is XORed with 8'h55.
- R6: When `hec_corrupt_en` is high, `hec_corrupt_mask` is XORed into the inserted HEC octet.
- R7: The 48 payload bytes of an idle cell carry `idle_payload` before scrambling.
- R8: With `scr_en` high, each payload bit, taken MSB first, is output as the input bit XOR the output bit 43 positions earlier in the scrambled payload sequence. The scrambler history starts at zero after reset. Header and HEC bytes are never scrambled and do not advance the history.
- R9: With `scr_en` low, payload bytes pass unchanged and the scrambler history holds.
- R10: For user cells, `hdr_hec_ok` or `hdr_hec_err` pulses for one cycle together with the output of byte 4. Which one pulses depends on whether the received byte 4 equals the generated HEC (with coset when `coset_en` is high). Neither flag pulses for idle cells.
- R11: Each cell is counted as user or idle in the cycle it starts. On an `interval` pulse, the live counts move to `user_cnt_q` and `idle_cnt_q`, and the live counts restart. A cell starting in that same cycle is counted in the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_rdy_i | input | 1 | Upstream holds a full user cell |
| rd_o | output | 1 | Byte request to the show-ahead store |
| din_i | input | 8 | User cell byte presented for the current request |
| hec_ins_en | input | 1 | Insert generated HEC into user cells |
| coset_en | input | 1 | Apply coset pattern to the HEC |
| hec_corrupt_en | input | 1 | Corrupt the inserted HEC |
| hec_corrupt_mask | input | 8 | Bits flipped when corrupting |
| scr_en | input | 1 | Scramble the payload |
| idle_gfc | input | 4 | Idle cell flow-control field |
| idle_pti | input | 3 | Idle cell payload-type field |
| idle_clp | input | 1 | Idle cell loss-priority bit |
| idle_payload | input | 8 | Idle cell payload byte |
| interval | input | 1 | End of accumulation interval |
| dout | output | 8 | Output byte |
| dout_soc | output | 1 | Byte 0 of a cell |
| dout_valid | output | 1 | Output byte valid |
| hdr_hec_ok | output | 1 | Received user HEC correct |
| hdr_hec_err | output | 1 | Received user HEC wrong |
| user_cnt_q | output | CNT_W | Held user cell count |
| idle_cnt_q | output | CNT_W | Held idle cell count |

## Verification
Some rules can be checked on every cycle, and assertions do so. The user/idle choice and the read request must stay fixed within a cell. The HEC flags may only follow a user cell's fifth byte. The scrambler history must stay frozen outside enabled payload bytes. A snapshot must equal the live counts from the cycle before. The actual byte values cannot be checked that way: the CRC, the coset and corruption arithmetic, and the 43-bit self-synchronous sequence across many cells. The same holds for the count totals under mixed user and idle traffic. Only the bench's sweep over every combination of the four controls, with a bit-serial reference model, shows those.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int SCR_DEPTH  = 43;
  localparam int POS_W      = $clog2(CELL_BYTES);
  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;

  typedef logic [POS_W-1:0] pos_t;

  localparam pos_t POS_HEC  = pos_t'(HDR_BYTES);
  localparam pos_t POS_LAST = pos_t'(CELL_BYTES - 1);

  // One byte of CRC-8 advance, MSB first.
  function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ b[i];
      c  = {c[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/atm_hec_unit.sv
module atm_hec_unit
  import atm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pos_t       pos,
  input  logic       is_user,
  input  logic [7:0] src,
  input  logic       ins_en,
  input  logic       coset_en,
  input  logic       corrupt_en,
  input  logic [7:0] corrupt_mask,
  output logic [7:0] hec_byte,
  output logic       hec_ok,
  output logic       hec_err
);
  logic [7:0] crc_q;
  logic [7:0] hec_gen;
  logic [7:0] hec_ins;

  assign hec_gen  = crc_q ^ (coset_en ? HEC_COSET : 8'h00);
  assign hec_ins  = hec_gen ^ (corrupt_en ? corrupt_mask : 8'h00);
  assign hec_byte = (ins_en || !is_user) ? hec_ins : src;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q   <= 8'h00;
      hec_ok  <= 1'b0;
      hec_err <= 1'b0;
    end else begin
      if (pos < POS_HEC)
        crc_q <= hec_step((pos == '0) ? 8'h00 : crc_q, src);
      hec_ok  <= (pos == POS_HEC) && is_user && (src == hec_gen);
      hec_err <= (pos == POS_HEC) && is_user && (src != hec_gen);
    end
  end

  // R10: a flag only follows the HEC byte of a user cell
  p_flag_user_r10: assert property (@(posedge clk) disable iff (rst)
    (hec_ok || hec_err) |-> ($past(pos) == POS_HEC && $past(is_user)));

  // R4: header CRC untouched while payload streams
  p_crc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pos > POS_HEC) |=> $stable(crc_q));
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler #(
  parameter int DEPTH = 43
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [DEPTH-1:0] state_q;
  logic [DEPTH-1:0] state_nx;
  logic [7:0]       scr;

  always_comb begin
    state_nx = state_q;
    scr      = '0;
    for (int i = 7; i >= 0; i--) begin
      scr[i]   = din[i] ^ state_nx[DEPTH-1];
      state_nx = {state_nx[DEPTH-2:0], scr[i]};
    end
  end

  assign dout = en ? scr : din;

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= '0;
    else if (adv && en)
      state_q <= state_nx;
  end

  // R8 / R9: history frozen on header bytes and while bypassed
  p_state_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(adv && en) |=> $stable(state_q));
endmodule

// File: rtl/atm_cell_counters.sv
module atm_cell_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_user,
  input  logic             interval,
  output logic [CNT_W-1:0] user_held,
  output logic [CNT_W-1:0] idle_held
);
  logic [CNT_W-1:0] user_live;
  logic [CNT_W-1:0] idle_live;
  logic             inc_user;
  logic             inc_idle;

  assign inc_user = start && is_user;
  assign inc_idle = start && !is_user;

  always_ff @(posedge clk) begin
    if (rst) begin
      user_live <= '0;
      idle_live <= '0;
      user_held <= '0;
      idle_held <= '0;
    end else if (interval) begin
      user_held <= user_live;
      idle_held <= idle_live;
      user_live <= CNT_W'(inc_user);
      idle_live <= CNT_W'(inc_idle);
    end else begin
      user_live <= user_live + CNT_W'(inc_user);
      idle_live <= idle_live + CNT_W'(inc_idle);
    end
  end

  // R11: snapshot equals the live counts of the previous cycle
  p_snap_r11: assert property (@(posedge clk) disable iff (rst)
    interval |=> (user_held == $past(user_live) && idle_held == $past(idle_live)));
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
  import atm_tx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_rdy_i,
  output logic             rd_o,
  input  logic [7:0]       din_i,
  input  logic             hec_ins_en,
  input  logic             coset_en,
  input  logic             hec_corrupt_en,
  input  logic [7:0]       hec_corrupt_mask,
  input  logic             scr_en,
  input  logic [3:0]       idle_gfc,
  input  logic [2:0]       idle_pti,
  input  logic             idle_clp,
  input  logic [7:0]       idle_payload,
  input  logic             interval,
  output logic [7:0]       dout,
  output logic             dout_soc,
  output logic             dout_valid,
  output logic             hdr_hec_ok,
  output logic             hdr_hec_err,
  output logic [CNT_W-1:0] user_cnt_q,
  output logic [CNT_W-1:0] idle_cnt_q
);
  pos_t       pos_q;
  logic       user_q;
  logic       start;
  logic       use_user;
  logic [7:0] idle_byte;
  logic [7:0] src;
  logic [7:0] hec_byte;
  logic [7:0] scr_byte;
  logic [7:0] out_byte;

  assign start    = (pos_q == '0);
  assign use_user = start ? cell_rdy_i : user_q;
  assign rd_o     = use_user;

  always_comb begin
    unique case (pos_q)
      pos_t'(0): idle_byte = {idle_gfc, 4'h0};
      pos_t'(1): idle_byte = 8'h00;
      pos_t'(2): idle_byte = 8'h00;
      pos_t'(3): idle_byte = {4'h0, idle_pti, idle_clp};
      default:   idle_byte = idle_payload;
    endcase
  end

  assign src = use_user ? din_i : idle_byte;

  atm_hec_unit u_hec (
    .clk          (clk),
    .rst          (rst),
    .pos          (pos_q),
    .is_user      (use_user),
    .src          (src),
    .ins_en       (hec_ins_en),
    .coset_en     (coset_en),
    .corrupt_en   (hec_corrupt_en),
    .corrupt_mask (hec_corrupt_mask),
    .hec_byte     (hec_byte),
    .hec_ok       (hdr_hec_ok),
    .hec_err      (hdr_hec_err)
  );

  atm_payload_scrambler #(.DEPTH(SCR_DEPTH)) u_scr (
    .clk  (clk),
    .rst  (rst),
    .adv  (pos_q > POS_HEC),
    .en   (scr_en),
    .din  (src),
    .dout (scr_byte)
  );

  atm_cell_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_user   (use_user),
    .interval  (interval),
    .user_held (user_cnt_q),
    .idle_held (idle_cnt_q)
  );

  always_comb begin
    if (pos_q < POS_HEC)       out_byte = src;
    else if (pos_q == POS_HEC) out_byte = hec_byte;
    else                       out_byte = scr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      user_q     <= 1'b0;
      dout       <= 8'h00;
      dout_soc   <= 1'b0;
      dout_valid <= 1'b0;
    end else begin
      pos_q      <= (pos_q == POS_LAST) ? '0 : pos_q + pos_t'(1);
      user_q     <= use_user;
      dout       <= out_byte;
      dout_soc   <= start;
      dout_valid <= 1'b1;
    end
  end

  // R2 / R3: the user-or-idle choice is fixed for the whole cell
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (pos_q != '0) |-> (rd_o == $past(rd_o)));

  // R3: an idle cell opens with the programmed flow-control field
  p_idle_first_r3: assert property (@(posedge clk) disable iff (rst)
    (dout_soc && !$past(rd_o)) |-> (dout == {$past(idle_gfc), 4'h0}));

  // R1: start-of-cell only on valid bytes
  p_soc_valid_r1: assert property (@(posedge clk) disable iff (rst)
    dout_soc |-> dout_valid);
endmodule

// File: tb/atm_tx_cell_proc_bench.sv
module atm_tx_cell_proc_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cell_rdy = 1'b0;
  logic          rd;
  logic [7:0]    din;
  logic          ins_en = 1'b0, coset = 1'b0, cor_en = 1'b0, scr = 1'b0;
  logic [7:0]    cor_mask = 8'h00;
  logic [3:0]    gfc = 4'h0;
  logic [2:0]    pti = 3'h0;
  logic          clp = 1'b0;
  logic [7:0]    ipay = 8'h6A;
  logic          intv = 1'b0;
  logic [7:0]    dout;
  logic          soc, vld, ok, err;
  logic [CW-1:0] ucq, icq;

  int checks = 0, fails = 0;
  bit mon_en = 0;
  bit done = 0;

  always #10 clk = ~clk;

  atm_tx_cell_proc #(.CNT_W(CW)) u_atm_tx_cell_proc (
    .clk(clk), .rst(rst), .cell_rdy_i(cell_rdy), .rd_o(rd), .din_i(din),
    .hec_ins_en(ins_en), .coset_en(coset), .hec_corrupt_en(cor_en),
    .hec_corrupt_mask(cor_mask), .scr_en(scr), .idle_gfc(gfc), .idle_pti(pti),
    .idle_clp(clp), .idle_payload(ipay), .interval(intv), .dout(dout),
    .dout_soc(soc), .dout_valid(vld), .hdr_hec_ok(ok), .hdr_hec_err(err),
    .user_cnt_q(ucq), .idle_cnt_q(icq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference CRC: XOR the byte in, then divide bit by bit
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] uhdr(input int n, input int k);
    case (k)
      0: return 8'(n) ^ 8'hA5;
      1: return 8'(n * 3);
      2: return 8'h10 + 8'(n);
      default: return {4'(n), 4'h2};
    endcase
  endfunction

  function automatic logic [7:0] ubyte(input int n, input int k, input logic cs);
    logic [7:0] h;
    if (k < 4) return uhdr(n, k);
    if (k == 4) begin
      h = 8'h00;
      for (int j = 0; j < 4; j++) h = ref_crc(h, uhdr(n, j));
      h = h ^ (cs ? 8'h55 : 8'h00);
      return (n % 3 == 0) ? (h ^ 8'h10) : h;
    end
    return 8'(n * 7 + k);
  endfunction

  // Upstream show-ahead store
  int ub = 0, ucnt = 0;
  assign din = ubyte(ucnt, ub, coset);
  always @(posedge clk) begin
    if (rst) begin ub <= 0; ucnt <= 0; end
    else if (rd) begin
      if (ub == 52) begin ub <= 0; ucnt <= ucnt + 1; end
      else ub <= ub + 1;
    end
  end

  // Reference model, stepped on each rising edge from the inputs
  int          mp = 0;
  logic        mu = 0;
  logic [7:0]  mc = 0;
  logic [42:0] ms = 0;
  int          mlu = 0, mli = 0, mhu = 0, mhi = 0;
  logic [7:0]  e_d = 0;
  logic        e_soc = 0, e_vld = 0, e_ok = 0, e_err = 0;
  string       e_tag = "R1";

  always @(posedge clk) begin
    logic [7:0] s, g;
    logic       o;
    if (rst) begin
      mp = 0; mu = 0; mc = 0; ms = '0; mlu = 0; mli = 0; mhu = 0; mhi = 0;
      e_d = 0; e_soc = 0; e_vld = 0; e_ok = 0; e_err = 0;
    end else begin
      if (mp == 0) mu = cell_rdy;
      if (intv) begin mhu = mlu; mhi = mli; mlu = 0; mli = 0; end
      if (mp == 0) begin if (mu) mlu++; else mli++; end
      case (mp)
        0: s = {gfc, 4'h0};
        1, 2: s = 8'h00;
        3: s = {4'h0, pti, clp};
        default: s = ipay;
      endcase
      if (mu) s = din;
      e_ok = 0; e_err = 0;
      if (mp < 4) begin
        if (mp == 0) mc = 8'h00;
        mc = ref_crc(mc, s);
        e_d = s;
        e_tag = mu ? "R2 header" : "R3 idle header";
      end else if (mp == 4) begin
        g = mc ^ (coset ? 8'h55 : 8'h00);
        if (mu) begin e_ok = (din == g); e_err = (din != g); end
        e_d = (ins_en || !mu) ? (g ^ (cor_en ? cor_mask : 8'h00)) : s;
        e_tag = "R4 R5 R6 hec";
      end else begin
        if (scr) begin
          for (int i = 7; i >= 0; i--) begin
            o = s[i] ^ ms[42];
            ms = {ms[41:0], o};
            e_d[i] = o;
          end
          e_tag = mu ? "R8 payload" : "R7 R8 idle payload";
        end else begin
          e_d = s;
          e_tag = "R9 bypass payload";
        end
      end
      e_soc = (mp == 0);
      e_vld = 1;
      mp = (mp == 52) ? 0 : mp + 1;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      check("R1 valid", 32'(vld), 32'(e_vld));
      check("R1 soc", 32'(soc), 32'(e_soc));
      check(e_tag, 32'(dout), 32'(e_d));
      check("R10 ok flag", 32'(ok), 32'(e_ok));
      check("R10 err flag", 32'(err), 32'(e_err));
      check("R11 user count", 32'(ucq), 32'(mhu));
      check("R11 idle count", 32'(icq), 32'(mhi));
    end
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(vld), 0);
    check("R1 reset soc", 32'(soc), 0);
    check("R1 reset flags", 32'({ok, err}), 0);
    check("R1 reset counts", 32'({ucq, icq}), 0);
    rst = 1'b0;
    mon_en = 1;
    for (int c = 0; c < 16; c++) begin
      ins_en = c[0]; coset = c[1]; cor_en = c[2]; scr = c[3];
      cor_mask = 8'h01 << c[2:0];
      gfc = 4'(c); pti = 3'(c + 1); clp = c[0];
      ipay = 8'h6A ^ 8'(c * 17);
      for (int t = 0; t < 53 * 6; t++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (c % 4)
          0: cell_rdy = 1'b1;
          1: cell_rdy = lf[0];
          2: cell_rdy = 1'b0;
          default: cell_rdy = ((t / 40) % 2) == 1;
        endcase
        @(negedge clk);
      end
      intv = 1'b1;
      @(negedge clk);
      intv = 1'b0;
      @(negedge clk);
      check("R11 snapshot total", 32'(ucq) + 32'(icq), 32'(mhu + mhi));
    end
    mon_en = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule